// File: doc/BRIEF.md
# Addressed SPI Slave Front End

This block is the receive and reply front end of an 8-bit SPI slave that can share a single chip-select line with up to three other slaves. Each slave has a 2-bit address strapped at its pins. The first two bits of every frame name the slave that is addressed. The reply line stays released until a slave recognises its own address. After that point, only the matching slave drives it. A slave whose address was not sent ignores the rest of the frame.

While the six payload bits arrive, the addressed slave sends back the visible part of a status byte. This byte is a fixed marker pattern with the error flag in its last bit. The flag tells the controller whether the previous access to this slave was broken. A frame is correct when it ends with exactly eight clock pulses. A correct frame hands the six payload bits to the core logic with a one-cycle strobe. A frame that is too short or too long is discarded and raises the error flag.

All pins are sampled in the system clock domain. Each SCK level must therefore last at least three system clocks, and CSN must stay high for at least three system clocks between frames.

Top module: `addr_spi_slave`

## Requirements
- R1: While rst_n is low, and right after it is released, sdo_oe, instr_vld and err_flag are 0, and instr is 0.
- R2: SDI is sampled on each falling SCK edge while CSN is low, MSB first. The first two bits form the frame address, and the first bit is the address MSB. The frame is addressed to this slave when that address equals addr_strap.
- R3: sdo_oe is 0 before the second falling edge of a frame. It goes to 1 after the second falling edge of an addressed frame and stays 1 until CSN goes high.
- R4: In a frame not addressed to this slave, sdo_oe stays 0, instr_vld never pulses, and err_flag and instr keep their values.
- R5: The status byte is {1,0,0,0,0,0,0,E}, where E is err_flag at the start of the frame. After k falling edges (k = 2..7), sdo carries byte bit 7-k. Bit 5 appears when sdo_oe rises, and each later rising SCK edge moves to the next bit, so bits 4 to 1 read 0 and the last bit reads E.
- R6: An addressed frame that ends (CSN high) after exactly 8 falling edges gives one instr_vld pulse of a single clock cycle. At that pulse, instr holds the last six received bits, and err_flag is 0.
- R7: An addressed frame that ends after any other number of falling edges (2..7 or more than 8) sets err_flag to 1. It gives no instr_vld and leaves instr unchanged.
- R8: A frame that ends with fewer than two falling edges has no effect on err_flag, instr or instr_vld.
- R9: CSN high returns the slave to its idle state, so the next frame is decoded from its first bit, even after an aborted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Shared chip select, active low (asynchronous) |
| sck | input | 1 | Serial clock, idles low (asynchronous) |
| sdi | input | 1 | Serial data from the controller |
| addr_strap | input | 2 | Strapped slave address |
| sdo | output | 1 | Serial reply data |
| sdo_oe | output | 1 | Enable for the external sdo pad driver |
| instr | output | 6 | Payload of the last correct frame |
| instr_vld | output | 1 | One-cycle strobe for a new payload |
| err_flag | output | 1 | Previous addressed access was malformed |

## Verification
The main sweep runs every strap value against every frame address with six payload patterns. These are all zeros, all ones, and alternating, single-bit and edge bits. The sweep separates address matching from bit order and catches swapped address bits or a shifted payload.

Separate sequences then try frames of the following lengths:
- zero edges,
- one edge,
- five edges,
- nine edges.

Each length is tried with a matching address, and the short frame also with a non-matching address. These runs show that the error flag is raised only by addressed malformed frames. They also show that the flag appears in the last reply bit of the next frame and is cleared by the next good frame.

// File: rtl/addr_spi_slave.sv
module addr_spi_slave #(
  parameter int FRAME_W = 8,
  parameter int ADDR_W  = 2,
  parameter int SYNC_N  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      sck,
  input  logic                      sdi,
  input  logic [ADDR_W-1:0]         addr_strap,
  output logic                      sdo,
  output logic                      sdo_oe,
  output logic [FRAME_W-ADDR_W-1:0] instr,
  output logic                      instr_vld,
  output logic                      err_flag
);
  localparam int PAY_W = FRAME_W - ADDR_W;
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] C_ADDR = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] C_MAX  = '1;

  logic [SYNC_N:0]    sck_q, cs_q;
  logic [SYNC_N-1:0]  sdi_q;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg, tx;
  logic               hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      sdi_q <= '0;
    end else begin
      sck_q <= {sck_q[SYNC_N-1:0], sck};
      cs_q  <= {cs_q[SYNC_N-1:0], cs_n};
      sdi_q <= {sdi_q[SYNC_N-2:0], sdi};
    end

  wire sdi_s    = sdi_q[SYNC_N-1];
  wire cs_lo    = ~cs_q[SYNC_N-1];
  wire cs_rise  = ~cs_q[SYNC_N] & cs_q[SYNC_N-1];
  wire sck_fall = sck_q[SYNC_N] & ~sck_q[SYNC_N-1];
  wire sck_rise = ~sck_q[SYNC_N] & sck_q[SYNC_N-1];
  wire live     = (cnt < C_ADDR) || hit;
  wire addr_ok  = {shreg[ADDR_W-2:0], sdi_s} == addr_strap;
  wire [FRAME_W-1:0] vbyte = {2'b10, {(FRAME_W-3){1'b0}}, err_flag};

  assign sdo = tx[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt       <= '0;
      shreg     <= '0;
      tx        <= '0;
      hit       <= 1'b0;
      sdo_oe    <= 1'b0;
      instr     <= '0;
      instr_vld <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      instr_vld <= 1'b0;
      if (cs_rise && hit) begin
        if (cnt == C_FULL) begin
          instr_vld <= 1'b1;
          instr     <= shreg[PAY_W-1:0];
          err_flag  <= 1'b0;
        end else
          err_flag  <= 1'b1;
      end
      if (!cs_lo) begin
        cnt    <= '0;
        hit    <= 1'b0;
        sdo_oe <= 1'b0;
        tx     <= '0;
      end else begin
        if (sck_fall) begin
          if (cnt != C_MAX) cnt <= cnt + 1'b1;
          if (live && cnt < C_FULL) shreg <= {shreg[FRAME_W-2:0], sdi_s};
          if (cnt == C_LAST && addr_ok) begin
            hit    <= 1'b1;
            sdo_oe <= 1'b1;
            tx     <= vbyte << ADDR_W;
          end
        end
        if (sck_rise && hit && cnt > C_ADDR && cnt < C_FULL)
          tx <= tx << 1;
      end
    end
endmodule

module addr_spi_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sdo,
  input logic sdo_oe,
  input logic instr_vld,
  input logic err_flag
);
  // R3
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);
  // R6
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld |=> !instr_vld);
  // R6
  vld_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld |-> !err_flag);
  // R5
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);
  // R7
  err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_flag) |-> $past(cs_n));
endmodule

bind addr_spi_slave addr_spi_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo),
  .sdo_oe(sdo_oe), .instr_vld(instr_vld), .err_flag(err_flag)
);

// File: tb/addr_spi_slave_bench.sv
module addr_spi_slave_bench;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [1:0] strap = 2'd0;
  logic sdo, sdo_oe, instr_vld, err_flag;
  logic [5:0] instr;

  int total = 0, bad = 0, vld_cnt = 0;
  logic exp_err = 1'b0;
  logic [5:0] exp_instr = '0;
  bit done = 0;

  always #2 clk = ~clk;

  addr_spi_slave u_addr_spi_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .addr_strap(strap), .sdo(sdo), .sdo_oe(sdo_oe), .instr(instr),
    .instr_vld(instr_vld), .err_flag(err_flag)
  );

  always @(negedge clk) if (rst_n && instr_vld) vld_cnt++;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] word, input int nbits);
    bit hitf = (nbits >= 2) && (word[7:6] == strap);
    logic [7:0] vb = {2'b10, 5'b0, exp_err};
    vld_cnt = 0;
    cs_n = 1'b0;
    waitn(H);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b1;
      sdi = (i < 8) ? word[7-i] : 1'b0;
      waitn(6);
      check("R3 oe after rise", int'(sdo_oe), int'(hitf && i >= 2));
      if (hitf && i >= 2 && i < 8) check("R5 reply bit", int'(sdo), int'(vb[7-i]));
      waitn(2);
      sck = 1'b0;
      waitn(6);
      check("R3 oe after fall", int'(sdo_oe), int'(hitf && i + 1 >= 2));
      waitn(2);
    end
    waitn(H);
    cs_n = 1'b1;
    waitn(12);
    if (hitf) begin
      if (nbits == 8) begin
        exp_err = 1'b0;
        exp_instr = word[5:0];
      end else exp_err = 1'b1;
    end
    check("R6 R7 vld count", vld_cnt, (hitf && nbits == 8) ? 1 : 0);
    check("R6 R7 R4 instr", int'(instr), int'(exp_instr));
    check("R7 R4 R8 err", int'(err_flag), int'(exp_err));
    check("R9 oe idle", int'(sdo_oe), 0);
  endtask

  initial begin
    logic [5:0] pays [6] = '{6'h00, 6'h3F, 6'h2A, 6'h15, 6'h01, 6'h20};
    waitn(5);
    check("R1 oe rst", int'(sdo_oe), 0);
    check("R1 vld rst", int'(instr_vld), 0);
    check("R1 err rst", int'(err_flag), 0);
    check("R1 instr rst", int'(instr), 0);
    rst_n = 1'b1;
    waitn(4);
    check("R1 oe after rst", int'(sdo_oe), 0);
    check("R1 err after rst", int'(err_flag), 0);

    // R2 R4 R6 sweep
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      waitn(4);
      for (int a = 0; a < 4; a++)
        for (int p = 0; p < 6; p++)
          run_frame({2'(a), pays[p]}, 8);
    end

    strap = 2'd2;
    waitn(4);
    run_frame(8'hA7, 5);   // R7 short addressed
    run_frame(8'hB3, 8);   // R5 err bit visible, R6 clears
    run_frame(8'hA1, 9);   // R7 long addressed
    run_frame(8'h4F, 5);   // R4 short, other address: err kept
    run_frame(8'hBC, 1);   // R8
    run_frame(8'hBC, 0);   // R8
    run_frame(8'h9E, 8);   // R9 good frame after aborts, R5 err=1 shown
    run_frame(8'h8D, 8);   // R5 err=0 shown again
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule